// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Lookup Unit

This unit turns an angle into the pair cos(x) and sin(x), one angle per clock, for use inside a datapath that multiplies complex samples by a rotation phasor. The angle arrives as an unsigned fixed-point value in radians with a valid flag. One multiply by a constant turns it into a 12-bit phase index. The upper two index bits name the quadrant. The lower ten bits address a table that holds only the first quarter of a sine wave.

Both outputs come from that one table. A dual-read ROM supplies two samples in the same cycle: one at the in-quadrant position and one at its mirrored position. The quadrant bits then decide whether the two samples swap places and which of them is negated. The results are signed Q1.15 values, and they appear a fixed three cycles after the angle, together with their own valid flag.

Top module: `cis_lut_unit`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and both cos_o and sin_o are 0.
- R2: valid_o equals valid_i delayed by exactly three clock cycles, with no gaps when valid_i is held high (one result per cycle).
- R3: angle_i is unsigned radians with 13 fraction bits. The phase index is bits [31:20] of angle_i × 83443, which wraps modulo 4096. Angle 0 gives index 0, which yields sin_o = 25 and cos_o = 32767.
- R4: Table entry k (0..1023) is round(32768·sin((k+0.5)·π/2048)), saturated to 32767. Index 1024, reached at angle 12868, yields sin_o = 32767 and cos_o = −25.
- R5: For index bits [11:10] = 0, sin_o is the table entry at p = index[9:0] and cos_o is the entry at the bitwise complement of p.
- R6: For index bits [11:10] = 1 or 3, the roles of the two table samples swap: the complement-address sample feeds sin_o and the direct sample feeds cos_o.
- R7: sin_o is negated in quadrants 2 and 3, and cos_o is negated in quadrants 1 and 2. Both are non-negative in quadrant 0.
- R8: Every valid output lies within 1 LSB of round(32768·f((i+0.5)·2π/4096)), where f is cos or sin and i is the index, limited to ±32767. The value −32768 never appears.
- R9: In a cycle where valid_o is low, cos_o and sin_o keep the values of the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Angle qualifier |
| angle_i | input | 16 | Unsigned angle in radians, 13 fraction bits |
| valid_o | output | 1 | Result qualifier, three cycles after valid_i |
| cos_o | output | 16 | Signed Q1.15 cosine |
| sin_o | output | 16 | Signed Q1.15 sine |

## Verification
The assertions assume that valid_i is a clean level sampled at the rising edge, and that angle_i may take any value, since the index simply wraps. The latency property also assumes that reset has been released for at least three cycles. A counter in the top module enforces this, so inputs driven during reset are never compared. The stimulus changes inputs only on the falling edge. It first runs two directed angles, then every 16-bit angle in turn, so that all 4096 indices occur back to back. It finishes with pseudo-random angles under a gated valid, which covers the hold behaviour of the outputs.

// File: rtl/cis_pkg.sv
package cis_pkg;
  localparam real PI_R = 3.14159265358979323846;

  // Q-format quarter-wave sample, midpoint-sampled, saturated to positive full scale
  function automatic int quarter_sample(int k, int addr_w, int data_w);
    real x, term, acc, full;
    int  v;
    x    = (real'(k) + 0.5) * (PI_R / 2.0) / real'(1 << addr_w);
    term = x;
    acc  = x;
    for (int n = 1; n < 12; n++) begin
      term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
      acc  = acc + term;
    end
    full = real'(1 << (data_w - 1));
    v    = $rtoi(acc * full + 0.5);
    if (v > (1 << (data_w - 1)) - 1) v = (1 << (data_w - 1)) - 1;
    return v;
  endfunction
endpackage

// File: rtl/cis_index_scaler.sv
module cis_index_scaler #(
  parameter int ANGLE_W = 16,
  parameter int IDX_W   = 12,
  parameter int SCALE_W = 17,
  parameter int SCALE   = 83443,
  parameter int SHIFT   = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ANGLE_W-1:0] angle_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam int PROD_W = ANGLE_W + SCALE_W;
  localparam logic [SCALE_W-1:0] SCALE_C = SCALE_W'(SCALE);

  logic [PROD_W-1:0] prod;
  assign prod = {{SCALE_W{1'b0}}, angle_i} * {{ANGLE_W{1'b0}}, SCALE_C};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) idx_o <= IDX_W'(prod >> SHIFT);
    end
  end
endmodule

// File: rtl/cis_quarter_rom.sv
module cis_quarter_rom #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        quad_i,
  input  logic [ADDR_W-1:0] pos_i,
  output logic              valid_o,
  output logic [1:0]        quad_o,
  output logic [DATA_W-1:0] direct_o,
  output logic [DATA_W-1:0] mirror_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] table_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    assign table_q[k] = DATA_W'(cis_pkg::quarter_sample(k, ADDR_W, DATA_W));
  end

  logic [ADDR_W-1:0] mirror_addr;
  assign mirror_addr = ~pos_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      quad_o   <= '0;
      direct_o <= '0;
      mirror_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        quad_o   <= quad_i;
        direct_o <= table_q[pos_i];
        mirror_o <= table_q[mirror_addr];
      end
    end
  end

  // table holds only non-negative quarter-wave samples (R4)
  p_table_positive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !direct_o[DATA_W-1] && !mirror_o[DATA_W-1]);
endmodule

// File: rtl/cis_quadrant_fold.sv
module cis_quadrant_fold #(
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [1:0]               quad_i,
  input  logic [DATA_W-1:0]        direct_i,
  input  logic [DATA_W-1:0]        mirror_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] sin_o,
  output logic signed [DATA_W-1:0] cos_o
);
  logic                     swap, neg_sin, neg_cos;
  logic signed [DATA_W-1:0] sin_mag, cos_mag, sin_nxt, cos_nxt;

  assign swap    = quad_i[0];
  assign neg_sin = quad_i[1];
  assign neg_cos = quad_i[1] ^ quad_i[0];
  assign sin_mag = swap ? mirror_i : direct_i;
  assign cos_mag = swap ? direct_i : mirror_i;
  assign sin_nxt = neg_sin ? -sin_mag : sin_mag;
  assign cos_nxt = neg_cos ? -cos_mag : cos_mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sin_o   <= '0;
      cos_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sin_o <= sin_nxt;
        cos_o <= cos_nxt;
      end
    end
  end

  p_first_quadrant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && quad_i == 2'd0 |=> !sin_o[DATA_W-1] && !cos_o[DATA_W-1]);

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sin_o) && $stable(cos_o));
endmodule

// File: rtl/cis_lut_unit.sv
module cis_lut_unit #(
  parameter int ANGLE_W = 16,
  parameter int IDX_W   = 12,
  parameter int DATA_W  = 16,
  parameter int SCALE_W = 17,
  parameter int SCALE   = 83443,
  parameter int SHIFT   = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [ANGLE_W-1:0]       angle_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] cos_o,
  output logic signed [DATA_W-1:0] sin_o
);
  localparam int ADDR_W = IDX_W - 2;

  logic              idx_vld, rom_vld;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        rom_quad;
  logic [DATA_W-1:0] rom_direct, rom_mirror;

  cis_index_scaler #(
    .ANGLE_W(ANGLE_W), .IDX_W(IDX_W), .SCALE_W(SCALE_W), .SCALE(SCALE), .SHIFT(SHIFT)
  ) u_scaler (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .angle_i(angle_i),
    .valid_o(idx_vld), .idx_o(idx)
  );

  cis_quarter_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(idx_vld),
    .quad_i(idx[IDX_W-1 -: 2]), .pos_i(idx[ADDR_W-1:0]),
    .valid_o(rom_vld), .quad_o(rom_quad), .direct_o(rom_direct), .mirror_o(rom_mirror)
  );

  cis_quadrant_fold #(.DATA_W(DATA_W)) u_fold (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(rom_vld), .quad_i(rom_quad),
    .direct_i(rom_direct), .mirror_i(rom_mirror),
    .valid_o(valid_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  // cycles since reset release, saturating, guards the latency check
  logic [1:0] live_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_cnt == 2'd3 |-> valid_o == $past(valid_i, 3));

  p_no_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sin_o != {1'b1, {(DATA_W-1){1'b0}}} && cos_o != {1'b1, {(DATA_W-1){1'b0}}});

  always_comb begin
    if (!rst_ni) p_reset_idle_r1: assert (valid_o == 1'b0 || $isunknown(valid_o));
  end
endmodule

// File: tb/cis_lut_unit_tb.sv
module cis_lut_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_in = 1'b0;
  logic [15:0] ang_in = '0;
  logic        vld_out;
  logic signed [15:0] cos_out, sin_out;

  int total = 0, bad = 0;

  cis_lut_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld_in), .angle_i(ang_in),
    .valid_o(vld_out), .cos_o(cos_out), .sin_o(sin_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference pipeline, behavioural
  bit pv[3];
  int ps[3], pc[3], pq[3], ptag[3];
  int cur_tag = 8;
  bit have_last = 0;
  int last_s = 0, last_c = 0;

  function automatic int rnd(real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int lim(int v);
    if (v > 32767) return 32767;
    if (v < -32767) return -32767;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) pv[i] = 0;
    end else begin
      longint prod;
      int idx;
      real th;
      for (int i = 2; i > 0; i--) begin
        pv[i] = pv[i-1]; ps[i] = ps[i-1]; pc[i] = pc[i-1]; pq[i] = pq[i-1]; ptag[i] = ptag[i-1];
      end
      prod  = longint'(ang_in) * 64'd83443;
      idx   = int'((prod >> 20) & 64'hFFF);
      th    = (real'(idx) + 0.5) * 2.0 * PI / 4096.0;
      pv[0] = vld_in;
      ps[0] = lim(rnd(32768.0 * $sin(th)));
      pc[0] = lim(rnd(32768.0 * $cos(th)));
      pq[0] = idx >> 10;
      ptag[0] = cur_tag;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit near(int a, int e);
    return (a - e <= 1) && (e - a <= 1);
  endfunction

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(vld_out == pv[2], "R2 valid", int'(vld_out), int'(pv[2]));
      if (pv[2] && vld_out) begin
        string lbl;
        case (ptag[2])
          3: lbl = "R3";
          4: lbl = "R4";
          default: lbl = (pq[2] % 2 == 1) ? "R6" : "R5";
        endcase
        chk(near(sin_out, ps[2]), {lbl, " sin"}, sin_out, ps[2]);
        chk(near(cos_out, pc[2]), {lbl, " cos"}, cos_out, pc[2]);
        if (ps[2] <= -2) chk(sin_out < 0, "R7 sin sign", sin_out, ps[2]);
        if (pc[2] <= -2) chk(cos_out < 0, "R7 cos sign", cos_out, pc[2]);
        chk(sin_out != -32768 && cos_out != -32768, "R8 range", sin_out, ps[2]);
        last_s = sin_out; last_c = cos_out; have_last = 1;
      end else if (!vld_out && have_last) begin
        chk(sin_out == last_s && cos_out == last_c, "R9 hold", sin_out, last_s);
      end
    end
  end

  task automatic drive(bit v, logic [15:0] a, int tag);
    @(negedge clk);
    vld_in = v; ang_in = a; cur_tag = tag;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk(vld_out == 0, "R1 valid", int'(vld_out), 0);
    chk(sin_out == 0 && cos_out == 0, "R1 data", sin_out, 0);
    rst_n = 1'b1;
    // directed: index 0 and index 1024
    drive(1, 16'd0, 3);
    drive(0, 16'd0, 8);
    drive(1, 16'd12868, 4);
    repeat (4) drive(0, 16'd0, 8);
    // full sweep covers every index
    for (int a = 0; a < 65536; a++) drive(1, 16'(a), 8);
    // gated valid with scrambled angles
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[3] & lfsr[7], lfsr ^ 16'h5A5A, 8);
    end
    repeat (5) drive(0, 16'd0, 8);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule